// File: doc/BRIEF.md
# Uncached Access Ordering Controller

This block sits between a CPU memory pipeline and a system bus and decides when uncached operations may leave for the bus. The pipeline hands it one operation per cycle, in program order: a cacheable coherent store, an uncached load, an uncached store or a barrier. Cacheable stores go into a small write buffer whose head an external agent accepts. The write buffer reports each store as visible one cycle after the accept. Uncached loads and stores wait in an ordered queue and go out over a valid/ready bus handshake.

An uncached access leaves only after every cacheable store that came before it is visible. An uncached store is also held while any uncached load is in flight. Uncached loads get one of a small pool of tags, and each tag is freed when its data returns. Cacheable stores that come after a waiting uncached access are not held back, so they may become visible first.

The barrier is held at the pipeline until four things are true: no loads of either kind are pending, every cacheable store is visible, no uncached store is left to send, and the write buffer with its visibility stage is empty. The pipeline is also stalled when it needs load data that has not yet returned.

Top module: `uc_order_ctrl`

## Requirements
- R1: Cacheable stores leave the write buffer in acceptance order. `wb_id_o` shows the oldest one while `wb_valid_o` is high. A cycle with `wb_accept_i` and `wb_valid_o` both high removes it, and `vis_valid_o` with that id in `vis_id_o` follows exactly one cycle later.
- R2: `op_kind_i` encodes 0 as cacheable store, 1 as uncached load, 2 as uncached store and 3 as barrier. Uncached operations appear on `bus_id_o` in acceptance order. Once `bus_valid_o` is high without `bus_ready_i`, it stays high next cycle with the same id and kind.
- R3: An uncached operation is not offered on the bus before every cacheable store accepted ahead of it has been removed from the write buffer. It may be offered in the same cycle as that store's `vis_valid_o`.
- R4: An uncached store (`bus_store_o`=1) is not offered while any uncached load is in flight. A load is in flight from its bus handshake until its `ld_ret_i`.
- R5: Up to MAX_LD (default 4) uncached loads may be in flight. Each one gets the lowest free tag on `bus_tag_o`. `ld_ret_i` frees `ld_ret_tag_i`. A load is not offered while every tag is busy.
- R6: `stall_o` is high whenever `need_i` is high and an uncached load is queued or in flight, or `miss_pend_i` is high. With `need_i` low these conditions do not stall.
- R7: A cacheable store accepted after a still-waiting uncached operation enters the write buffer and may become visible before that operation is offered.
- R8: A barrier (kind 3) stalls until all four of these hold: no uncached load is queued or in flight and `miss_pend_i` is low; the write buffer is empty; no uncached store is queued; no visibility pulse is pending. It is then accepted with no other effect.
- R9: A cacheable store stalls while the write buffer holds WB_DEPTH (8) entries. An uncached operation stalls while the queue holds UQ_DEPTH (4) entries.
- R10: After reset, `stall_o`, `bus_valid_o`, `wb_valid_o` and `vis_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Pipeline presents an operation |
| op_kind_i | input | 2 | Operation kind (R2 encoding) |
| op_id_i | input | ID_W | Operation identifier |
| need_i | input | 1 | Pipeline needs the result of a load |
| miss_pend_i | input | 1 | A cacheable load miss is outstanding |
| stall_o | output | 1 | Operation not taken / pipeline held |
| wb_valid_o | output | 1 | Write buffer head present |
| wb_id_o | output | ID_W | Write buffer head id |
| wb_accept_i | input | 1 | Head store taken by the coherent memory |
| vis_valid_o | output | 1 | A cacheable store became visible |
| vis_id_o | output | ID_W | Id of the visible store |
| bus_valid_o | output | 1 | Uncached operation offered |
| bus_ready_i | input | 1 | Bus takes the operation |
| bus_store_o | output | 1 | Offered operation is a store |
| bus_id_o | output | ID_W | Id of the offered operation |
| bus_tag_o | output | TAG_W | Tag given to an offered load |
| ld_ret_i | input | 1 | Uncached load data returned |
| ld_ret_tag_i | input | TAG_W | Tag of the returned load |

## Verification
A cycle table drives a mixed stream. In it a store waits on an earlier cacheable store's visibility, a load is held against a stalled bus, and a store is held behind an in-flight load while a younger cacheable store overtakes it. This separates the visibility gate from the load gate and from plain back-pressure. Directed runs then show each barrier condition holding the stall on its own, and the need stall for queued loads, in-flight loads and cache misses. Further runs fill the tag pool to show tag order and reuse after an out-of-order return, and fill both queues to show the full stalls. Long cacheable bursts show visibility order.

// File: rtl/uc_order_pkg.sv
package uc_order_pkg;
  typedef enum logic [1:0] {
    K_CST  = 2'd0,
    K_ULD  = 2'd1,
    K_UST  = 2'd2,
    K_SYNC = 2'd3
  } op_kind_e;
endpackage

// File: rtl/ord_fifo.sv
module ord_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [W-1:0]                 din_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 dout_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign count_o = cnt_q;
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  // R9: the controller must never overfill or underrun the buffer
  a_r9_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r1_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/uc_queue.sv
module uc_queue #(
  parameter int ID_W  = 8,
  parameter int DEPTH = 4,
  parameter int WC_W  = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic                         push_store_i,
  input  logic [ID_W-1:0]              push_id_i,
  input  logic [WC_W-1:0]              push_wait_i,
  input  logic                         vis_i,
  input  logic                         pop_i,
  output logic                         head_valid_o,
  output logic                         head_store_o,
  output logic [ID_W-1:0]              head_id_o,
  output logic                         head_clear_o,
  output logic                         full_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic [$clog2(DEPTH+1)-1:0]   st_cnt_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [PW-1:0]   rd_q, wr_q;
  logic [CW-1:0]   cnt_q, st_q;
  logic [ID_W-1:0] id_arr   [DEPTH];
  logic            st_arr   [DEPTH];
  logic [WC_W-1:0] wait_arr [DEPTH];

  // each entry counts the older cacheable stores still not visible
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [ID_W-1:0] id_q;
    logic            st_q;
    logic [WC_W-1:0] wait_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_q   <= '0;
        st_q   <= 1'b0;
        wait_q <= '0;
      end else if (push_i && wr_q == PW'(i)) begin
        id_q   <= push_id_i;
        st_q   <= push_store_i;
        wait_q <= push_wait_i;
      end else if (vis_i && wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end
    end
    assign id_arr[i]   = id_q;
    assign st_arr[i]   = st_q;
    assign wait_arr[i] = wait_q;
  end

  assign head_valid_o = (cnt_q != '0);
  assign head_store_o = st_arr[rd_q];
  assign head_id_o    = id_arr[rd_q];
  assign head_clear_o = (wait_arr[rd_q] == '0);
  assign full_o       = (cnt_q == CW'(DEPTH));
  assign count_o      = cnt_q;
  assign st_cnt_o     = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      st_q  <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      case ({push_i && push_store_i, pop_i && head_store_o})
        2'b10:   st_q <= st_q + 1'b1;
        2'b01:   st_q <= st_q - 1'b1;
        default: st_q <= st_q;
      endcase
    end
  end

  a_r9_uq_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R3: an entry is only removed once its older cacheable stores are visible
  a_r3_pop_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> head_valid_o && head_clear_o);
endmodule

// File: rtl/ld_tag_tracker.sv
module ld_tag_tracker #(
  parameter int N = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              alloc_i,
  input  logic                              free_i,
  input  logic [((N > 1) ? $clog2(N) : 1)-1:0] free_tag_i,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] tag_o,
  output logic                              full_o,
  output logic [$clog2(N+1)-1:0]            cnt_o
);
  localparam int TW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N+1);

  logic [N-1:0] busy_q;
  logic         found;

  always_comb begin
    tag_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!busy_q[i] && !found) begin
        tag_o = TW'(i);
        found = 1'b1;
      end
    end
  end

  assign full_o = &busy_q;
  assign cnt_o  = CW'($countones(busy_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (alloc_i && tag_o == TW'(i))         busy_q[i] <= 1'b1;
        else if (free_i && free_tag_i == TW'(i)) busy_q[i] <= 1'b0;
      end
    end
  end

  // R5: no allocation with the pool exhausted; only busy tags return
  a_r5_no_alloc_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !full_o);
  a_r5_free_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> busy_q[free_tag_i]);
endmodule

// File: rtl/uc_order_ctrl.sv
module uc_order_ctrl
  import uc_order_pkg::*;
#(
  parameter int ID_W     = 8,
  parameter int WB_DEPTH = 8,
  parameter int UQ_DEPTH = 4,
  parameter int MAX_LD   = 4,
  localparam int TAG_W   = (MAX_LD > 1) ? $clog2(MAX_LD) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [1:0]       op_kind_i,
  input  logic [ID_W-1:0]  op_id_i,
  input  logic             need_i,
  input  logic             miss_pend_i,
  output logic             stall_o,
  output logic             wb_valid_o,
  output logic [ID_W-1:0]  wb_id_o,
  input  logic             wb_accept_i,
  output logic             vis_valid_o,
  output logic [ID_W-1:0]  vis_id_o,
  output logic             bus_valid_o,
  input  logic             bus_ready_i,
  output logic             bus_store_o,
  output logic [ID_W-1:0]  bus_id_o,
  output logic [TAG_W-1:0] bus_tag_o,
  input  logic             ld_ret_i,
  input  logic [TAG_W-1:0] ld_ret_tag_i
);
  localparam int WB_CW = $clog2(WB_DEPTH+1);
  localparam int UQ_CW = $clog2(UQ_DEPTH+1);
  localparam int LD_CW = $clog2(MAX_LD+1);

  op_kind_e kind;
  assign kind = op_kind_e'(op_kind_i);

  logic             wb_empty, wb_full, wb_push, wb_pop;
  logic [WB_CW-1:0] wb_cnt;
  logic [ID_W-1:0]  wb_head;
  logic             vis_q;
  logic [ID_W-1:0]  vis_id_q;

  logic             uq_full, uq_push, uq_pop;
  logic             hd_valid, hd_store, hd_clear;
  logic [ID_W-1:0]  hd_id;
  logic [UQ_CW-1:0] uq_cnt, uq_st_cnt, uq_ld_cnt;
  logic [WB_CW-1:0] push_wait;

  logic             trk_full, ld_alloc;
  logic [LD_CW-1:0] ld_cnt;
  logic [TAG_W-1:0] free_tag;

  logic loads_pend, need_stall, res_stall, sync_ok, sync_stall, acc, bus_fire;

  // stall decisions
  assign uq_ld_cnt  = uq_cnt - uq_st_cnt;
  assign loads_pend = (ld_cnt != '0) || (uq_ld_cnt != '0);
  assign need_stall = need_i && (loads_pend || miss_pend_i);
  assign res_stall  = ((kind == K_CST) && wb_full) ||
                      (((kind == K_ULD) || (kind == K_UST)) && uq_full);
  assign sync_ok    = !loads_pend && !miss_pend_i && (uq_st_cnt == '0) &&
                      wb_empty && !vis_q;
  assign sync_stall = (kind == K_SYNC) && !sync_ok;
  assign stall_o    = need_stall || (op_valid_i && (res_stall || sync_stall));
  assign acc        = op_valid_i && !stall_o;

  // write buffer
  assign wb_push = acc && (kind == K_CST);
  assign wb_pop  = wb_accept_i && !wb_empty;

  ord_fifo #(.W(ID_W), .DEPTH(WB_DEPTH)) u_wb (
    .clk_i, .rst_ni,
    .push_i (wb_push),
    .din_i  (op_id_i),
    .pop_i  (wb_pop),
    .dout_o (wb_head),
    .empty_o(wb_empty),
    .full_o (wb_full),
    .count_o(wb_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_q    <= 1'b0;
      vis_id_q <= '0;
    end else begin
      vis_q <= wb_pop;
      if (wb_pop) vis_id_q <= wb_head;
    end
  end

  assign wb_valid_o  = !wb_empty;
  assign wb_id_o     = wb_head;
  assign vis_valid_o = vis_q;
  assign vis_id_o    = vis_id_q;

  // uncached queue; a store popped this cycle is already visible
  assign uq_push   = acc && ((kind == K_ULD) || (kind == K_UST));
  assign push_wait = wb_cnt - WB_CW'(wb_pop);

  uc_queue #(.ID_W(ID_W), .DEPTH(UQ_DEPTH), .WC_W(WB_CW)) u_uq (
    .clk_i, .rst_ni,
    .push_i      (uq_push),
    .push_store_i(kind == K_UST),
    .push_id_i   (op_id_i),
    .push_wait_i (push_wait),
    .vis_i       (wb_pop),
    .pop_i       (uq_pop),
    .head_valid_o(hd_valid),
    .head_store_o(hd_store),
    .head_id_o   (hd_id),
    .head_clear_o(hd_clear),
    .full_o      (uq_full),
    .count_o     (uq_cnt),
    .st_cnt_o    (uq_st_cnt)
  );

  // bus issue
  assign bus_valid_o = hd_valid && hd_clear &&
                       (hd_store ? (ld_cnt == '0) : !trk_full);
  assign bus_store_o = hd_store;
  assign bus_id_o    = hd_id;
  assign bus_tag_o   = free_tag;
  assign bus_fire    = bus_valid_o && bus_ready_i;
  assign uq_pop      = bus_fire;
  assign ld_alloc    = bus_fire && !hd_store;

  ld_tag_tracker #(.N(MAX_LD)) u_trk (
    .clk_i, .rst_ni,
    .alloc_i   (ld_alloc),
    .free_i    (ld_ret_i),
    .free_tag_i(ld_ret_tag_i),
    .tag_o     (free_tag),
    .full_o    (trk_full),
    .cnt_o     (ld_cnt)
  );

  a_r2_hold_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_id_o) && $stable(bus_store_o));
  a_r4_store_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_store_o |-> ld_cnt == '0);
  a_r1_vis_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vis_valid_o |-> $past(wb_accept_i && wb_valid_o));
  a_r8_sync_drained: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && kind == K_SYNC |-> wb_empty && ld_cnt == '0 && uq_cnt == '0);
endmodule

// File: tb/uc_order_ctrl_tb.sv
`timescale 1ns/100ps
module uc_order_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid, need, miss, wacc, brdy, ret;
  logic [1:0] op_kind, rtag;
  logic [7:0] op_id;
  logic       stall, wbv, visv, bv, bst;
  logic [7:0] wbid, visid, bid;
  logic [1:0] btag;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uc_order_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .op_valid_i(op_valid), .op_kind_i(op_kind), .op_id_i(op_id),
    .need_i(need), .miss_pend_i(miss), .stall_o(stall),
    .wb_valid_o(wbv), .wb_id_o(wbid), .wb_accept_i(wacc),
    .vis_valid_o(visv), .vis_id_o(visid),
    .bus_valid_o(bv), .bus_ready_i(brdy), .bus_store_o(bst),
    .bus_id_o(bid), .bus_tag_o(btag),
    .ld_ret_i(ret), .ld_ret_tag_i(rtag)
  );

  typedef struct packed {
    logic       opv; logic [1:0] kind; logic [7:0] id;
    logic       need; logic wacc; logic brdy; logic ret; logic [1:0] rtag;
    logic       e_stall; logic e_bv; logic [7:0] e_bid; logic e_wbv; logic e_visv;
  } vec_t;

  // kinds: 0 cstore, 1 uload, 2 ustore, 3 barrier
  localparam vec_t TBL [14] = '{
    '{1'b1, 2'd0, 8'd10, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0},
    '{1'b1, 2'd2, 8'd20, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd0,  1'b1, 1'b0},
    '{1'b0, 2'd0, 8'd0,  1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'd0,  1'b1, 1'b0},
    '{1'b0, 2'd0, 8'd0,  1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'd0,  1'b1, 1'b0},
    '{1'b0, 2'd0, 8'd0,  1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 8'd20, 1'b0, 1'b1},
    '{1'b1, 2'd1, 8'd30, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0},
    '{1'b1, 2'd2, 8'd31, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 8'd30, 1'b0, 1'b0},
    '{1'b0, 2'd0, 8'd0,  1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 8'd30, 1'b0, 1'b0},
    '{1'b1, 2'd0, 8'd40, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0},
    '{1'b0, 2'd0, 8'd0,  1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'd0,  1'b1, 1'b0},
    '{1'b0, 2'd0, 8'd0,  1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 8'd0,  1'b0, 1'b1},
    '{1'b0, 2'd0, 8'd0,  1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0},
    '{1'b0, 2'd0, 8'd0,  1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 8'd31, 1'b0, 1'b0},
    '{1'b0, 2'd0, 8'd0,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'd0,  1'b0, 1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drv(input logic v, input logic [1:0] k, input logic [7:0] id,
                     input logic nd, input logic ms, input logic wa, input logic br,
                     input logic rt, input logic [1:0] tg);
    @(negedge clk);
    op_valid = v; op_kind = k; op_id = id; need = nd; miss = ms;
    wacc = wa; brdy = br; ret = rt; rtag = tg;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    op_valid = 0; op_kind = 0; op_id = 0; need = 0; miss = 0;
    wacc = 0; brdy = 0; ret = 0; rtag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    drv(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R10", "stall", stall, 0);
    chk("R10", "bus_valid", bv, 0);
    chk("R10", "wb_valid", wbv, 0);
    chk("R10", "vis_valid", visv, 0);

    // table: R2 R3 R4 R7
    for (int i = 0; i < 14; i++) begin
      drv(TBL[i].opv, TBL[i].kind, TBL[i].id, TBL[i].need, 1'b0, TBL[i].wacc,
          TBL[i].brdy, TBL[i].ret, TBL[i].rtag);
      chk($sformatf("R2/R3/R4/R7 row %0d", i), "stall", stall, TBL[i].e_stall);
      chk($sformatf("R2/R3/R4/R7 row %0d", i), "bus_valid", bv, TBL[i].e_bv);
      if (TBL[i].e_bv) chk($sformatf("R2 row %0d", i), "bus_id", bid, TBL[i].e_bid);
      chk($sformatf("R1/R7 row %0d", i), "wb_valid", wbv, TBL[i].e_wbv);
      chk($sformatf("R1/R7 row %0d", i), "vis_valid", visv, TBL[i].e_visv);
    end

    // R8 barrier conditions
    drv(1, 0, 50, 0, 0, 0, 0, 0, 0);
    chk("R8", "stall cstore", stall, 0);
    drv(1, 3, 0, 0, 0, 1, 0, 0, 0);
    chk("R8", "stall wb nonempty", stall, 1);
    drv(1, 3, 0, 0, 0, 0, 0, 0, 0);
    chk("R8", "stall vis pending", stall, 1);
    chk("R1", "vis_valid", visv, 1);
    chk("R1", "vis_id", visid, 50);
    drv(1, 3, 0, 0, 0, 0, 0, 0, 0);
    chk("R8", "stall drained", stall, 0);
    drv(1, 3, 0, 0, 1, 0, 0, 0, 0);
    chk("R8", "stall miss", stall, 1);
    drv(1, 2, 60, 0, 0, 0, 0, 0, 0);
    chk("R8", "ustore taken", stall, 0);
    drv(1, 3, 0, 0, 0, 0, 1, 0, 0);
    chk("R8", "stall store unsent", stall, 1);
    chk("R2", "bus_id", bid, 60);
    drv(1, 3, 0, 0, 0, 0, 0, 0, 0);
    chk("R8", "stall after send", stall, 0);

    // R6 need stall
    drv(1, 1, 70, 0, 0, 0, 0, 0, 0);
    chk("R6", "uload taken", stall, 0);
    drv(0, 0, 0, 1, 0, 0, 1, 0, 0);
    chk("R6", "stall queued load", stall, 1);
    chk("R5", "bus_tag first", btag, 0);
    drv(0, 0, 0, 1, 0, 0, 0, 1, 0);
    chk("R6", "stall inflight load", stall, 1);
    drv(0, 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R6", "stall after return", stall, 0);
    drv(0, 0, 0, 1, 1, 0, 0, 0, 0);
    chk("R6", "stall miss", stall, 1);
    drv(0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk("R6", "miss without need", stall, 0);

    // R5 tag pool, R9 queue full
    for (int i = 0; i < 4; i++) begin
      drv(1, 1, 8'(80 + i), 0, 0, 0, 0, 0, 0);
      chk("R9", "uload taken", stall, 0);
    end
    drv(1, 1, 84, 0, 0, 0, 0, 0, 0);
    chk("R9", "stall uq full", stall, 1);
    for (int i = 0; i < 4; i++) begin
      drv(0, 0, 0, 0, 0, 0, 1, 0, 0);
      chk("R5", "bus_valid", bv, 1);
      chk("R2", "bus_id", bid, 80 + i);
      chk("R5", "bus_tag", btag, i);
    end
    drv(1, 1, 85, 0, 0, 0, 1, 0, 0);
    chk("R5", "bus_valid empty", bv, 0);
    drv(0, 0, 0, 0, 0, 0, 1, 1, 2);
    chk("R5", "bus_valid pool full", bv, 0);
    drv(0, 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R5", "bus_valid reuse", bv, 1);
    chk("R5", "bus_id reuse", bid, 85);
    chk("R5", "bus_tag reuse", btag, 2);
    for (int i = 0; i < 4; i++) drv(0, 0, 0, 0, 0, 0, 0, 1, 2'(i));

    // R9 write buffer full, R1 order
    for (int i = 0; i < 8; i++) begin
      drv(1, 0, 8'(100 + i), 0, 0, 0, 0, 0, 0);
      chk("R9", "cstore taken", stall, 0);
    end
    drv(1, 0, 108, 0, 0, 0, 0, 0, 0);
    chk("R9", "stall wb full", stall, 1);
    for (int i = 0; i < 8; i++) begin
      drv(0, 0, 0, 0, 0, 1, 0, 0, 0);
      chk("R1", "wb_id", wbid, 100 + i);
      if (i > 0) begin
        chk("R1", "vis_valid", visv, 1);
        chk("R1", "vis_id", visid, 99 + i);
      end
    end
    drv(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R1", "vis_id last", visid, 107);
    chk("R1", "wb_valid empty", wbv, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule